// File: doc/BRIEF.md
# Partitionable SIMD Integer ALU

This block is a 32-bit integer ALU whose datapath can be cut into one 32-bit lane, two 16-bit lanes or four 8-bit lanes. One operation is issued every clock cycle. The second operand first passes through a left rotator. The ALU then applies one of add, subtract, AND, OR, XOR or pass to every active lane at once. Carries stop at each lane edge, so each lane computes a result that does not depend on its neighbours.

The result is registered. At the same clock edge the block captures per-lane carry, zero and negative flags, together with the lane mode that produced them.

A mask expander works from the stored flags of the selected kind. It widens each lane's flag bit into a lane full of ones or a lane full of zeros. Later select or merge logic can use this mask without decoding the lanes again.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, `result`, `carry_flags`, `zero_flags` and `neg_flags` are all zero, and `lane_mask` is zero for every value of `mask_sel`.
- R2: Operands presented in one cycle appear on `result` and on the flag outputs after the next rising clock edge. Before that edge the outputs still hold the previous operation.
- R3: `op` encodings:
  - 0: `opa + b'`
  - 1: `opa - b'`
  - 2: AND
  - 3: OR
  - 4: XOR
  - 5: pass `b'`
  - 6 and 7: pass `b'`, the same as 5.

  Here `b'` is the rotated `opb`, and every operation works lane by lane.
- R4: `b'` is `opb` rotated left by `rot_amt` (0 to 31) before every operation. A `rot_amt` of 0 leaves `opb` unchanged.
- R5: `mode` encodings are 0 for one 32-bit lane, 1 for two 16-bit lanes and 2 for four 8-bit lanes. Mode 3 behaves as mode 2. Lane n occupies the n-th group of bits counted from bit 0. No carry or borrow crosses a lane edge.
- R6: After add, a lane's carry flag is the carry out of that lane. After subtract, it is 1 exactly when the lane of `opa` is unsigned greater than or equal to the lane of `b'`, meaning no borrow. After ops 2 to 7, all carry flags are 0.
- R7: For each active lane, the zero flag is 1 when the lane result is all zeros. The negative flag equals the lane result's top bit.
- R8: Flag bits of lanes that the mode does not use are 0. In mode 0 that is bits 3:1. In mode 1 it is bits 3:2.
- R9: `lane_mask` takes the stored flags picked by `mask_sel`:
  - 0: carry
  - 1: zero
  - 2: negative
  - 3: no flags, so the mask is zero.

  Under the stored lane mode, each lane whose picked flag is 1 is all ones in `lane_mask` and every other lane is zeros. The mask follows `mask_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Lane mode: 0 one lane, 1 two lanes, 2 or 3 four lanes |
| op | input | 3 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, rotated before use |
| rot_amt | input | 5 | Left rotate amount applied to `opb` |
| mask_sel | input | 2 | Flag kind for the mask expander |
| result | output | 32 | Registered lane-wise result |
| carry_flags | output | 4 | Per-lane carry or no-borrow flags |
| zero_flags | output | 4 | Per-lane zero flags |
| neg_flags | output | 4 | Per-lane negative flags |
| lane_mask | output | 32 | Lane masks expanded from the stored flags |

## Verification
The hardest case to reach from the ports is a carry or borrow that ripples right up to a lane edge. For this to happen, a lane must be all ones or all zeros while the operand in the lane below produces a carry, and uniform random operands almost never line up that way. The stimulus therefore builds operands byte by byte, drawing each byte as 00, FF or a random value, and adds rotation and mode changes on top. Directed cases set up exact wraps of 0xFF, 0xFFFF and 0xFFFFFFFF, equal-operand subtraction and rotate amounts of 0 and 31.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
    typedef enum logic [1:0] {
        LANES_1X32 = 2'd0,
        LANES_2X16 = 2'd1,
        LANES_4X8  = 2'd2
    } lane_mode_e;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_PASS = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_CARRY = 2'd0,
        SEL_ZERO  = 2'd1,
        SEL_NEG   = 2'd2,
        SEL_NONE  = 2'd3
    } mask_sel_e;
endpackage

// File: rtl/simd_rotl.sv
module simd_rotl #(
    parameter int W = 32,
    localparam int RW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [RW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] doubled;

    always_comb begin
        doubled = {din, din} << amt;
        dout    = doubled[2*W-1:W];
    end
endmodule

// File: rtl/simd_slice_alu.sv
module simd_slice_alu
    import simd_alu_pkg::*;
#(
    parameter int SLICE_W = 8,
    parameter int SLICES  = 4,
    localparam int W      = SLICE_W * SLICES,
    localparam int HALF   = SLICES / 2
) (
    input  logic [1:0]        mode,
    input  logic [2:0]        op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [W-1:0]      res,
    output logic [SLICES-1:0] cout
);
    logic              is_sub;
    logic [SLICES-1:0] lane_start;
    logic [SLICES-1:0] chain_in;

    assign is_sub = (op == OP_SUB);

    // A slice that opens a lane takes the op carry-in; others ripple.
    always_comb begin
        for (int k = 0; k < SLICES; k++) begin
            case (mode)
                LANES_1X32: lane_start[k] = (k == 0);
                LANES_2X16: lane_start[k] = ((k % HALF) == 0);
                default:    lane_start[k] = 1'b1;
            endcase
        end
    end

    assign chain_in[0] = 1'b0;

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        logic [SLICE_W-1:0] a_s;
        logic [SLICE_W-1:0] b_s;
        logic [SLICE_W-1:0] b_eff;
        logic               cin;
        logic [SLICE_W:0]   sum;

        assign a_s   = a[k*SLICE_W +: SLICE_W];
        assign b_s   = b[k*SLICE_W +: SLICE_W];
        assign b_eff = is_sub ? ~b_s : b_s;
        assign cin   = lane_start[k] ? is_sub : chain_in[k];
        assign sum   = {1'b0, a_s} + {1'b0, b_eff} + {{SLICE_W{1'b0}}, cin};
        assign cout[k] = sum[SLICE_W];

        if (k < SLICES - 1) begin : g_chain
            assign chain_in[k+1] = sum[SLICE_W];
        end

        always_comb begin
            case (op)
                OP_ADD, OP_SUB: res[k*SLICE_W +: SLICE_W] = sum[SLICE_W-1:0];
                OP_AND:         res[k*SLICE_W +: SLICE_W] = a_s & b_s;
                OP_OR:          res[k*SLICE_W +: SLICE_W] = a_s | b_s;
                OP_XOR:         res[k*SLICE_W +: SLICE_W] = a_s ^ b_s;
                default:        res[k*SLICE_W +: SLICE_W] = b_s;
            endcase
        end
    end
endmodule

// File: rtl/simd_flag_gen.sv
module simd_flag_gen
    import simd_alu_pkg::*;
#(
    parameter int SLICE_W = 8,
    parameter int SLICES  = 4,
    localparam int W      = SLICE_W * SLICES,
    localparam int HALF   = SLICES / 2,
    localparam int HW     = HALF * SLICE_W
) (
    input  logic [1:0]        mode,
    input  logic [2:0]        op,
    input  logic [W-1:0]      res,
    input  logic [SLICES-1:0] cout,
    output logic [SLICES-1:0] carry,
    output logic [SLICES-1:0] zero,
    output logic [SLICES-1:0] neg
);
    logic arith;

    assign arith = (op == OP_ADD) || (op == OP_SUB);

    always_comb begin
        carry = '0;
        zero  = '0;
        neg   = '0;
        case (mode)
            LANES_1X32: begin
                carry[0] = cout[SLICES-1];
                zero[0]  = (res == '0);
                neg[0]   = res[W-1];
            end
            LANES_2X16: begin
                for (int l = 0; l < 2; l++) begin
                    carry[l] = cout[l*HALF + HALF - 1];
                    zero[l]  = (res[l*HW +: HW] == '0);
                    neg[l]   = res[l*HW + HW - 1];
                end
            end
            default: begin
                for (int l = 0; l < SLICES; l++) begin
                    carry[l] = cout[l];
                    zero[l]  = (res[l*SLICE_W +: SLICE_W] == '0);
                    neg[l]   = res[l*SLICE_W + SLICE_W - 1];
                end
            end
        endcase
        if (!arith) begin
            carry = '0;
        end
    end
endmodule

// File: rtl/simd_mask_expand.sv
module simd_mask_expand
    import simd_alu_pkg::*;
#(
    parameter int SLICE_W = 8,
    parameter int SLICES  = 4,
    localparam int W      = SLICE_W * SLICES,
    localparam int HALF   = SLICES / 2
) (
    input  logic [1:0]        mode,
    input  logic [1:0]        sel,
    input  logic [SLICES-1:0] carry,
    input  logic [SLICES-1:0] zero,
    input  logic [SLICES-1:0] neg,
    output logic [W-1:0]      mask
);
    logic [SLICES-1:0] picked;

    always_comb begin
        case (sel)
            SEL_CARRY: picked = carry;
            SEL_ZERO:  picked = zero;
            SEL_NEG:   picked = neg;
            default:   picked = '0;
        endcase
    end

    for (genvar k = 0; k < SLICES; k++) begin : g_lane
        always_comb begin
            case (mode)
                LANES_1X32: mask[k*SLICE_W +: SLICE_W] = {SLICE_W{picked[0]}};
                LANES_2X16: mask[k*SLICE_W +: SLICE_W] = {SLICE_W{picked[k/HALF]}};
                default:    mask[k*SLICE_W +: SLICE_W] = {SLICE_W{picked[k]}};
            endcase
        end
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu #(
    parameter int SLICE_W = 8,
    parameter int SLICES  = 4,
    localparam int W      = SLICE_W * SLICES,
    localparam int RW     = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [2:0]        op,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic [RW-1:0]     rot_amt,
    input  logic [1:0]        mask_sel,
    output logic [W-1:0]      result,
    output logic [SLICES-1:0] carry_flags,
    output logic [SLICES-1:0] zero_flags,
    output logic [SLICES-1:0] neg_flags,
    output logic [W-1:0]      lane_mask
);
    logic [W-1:0]      b_rot;
    logic [W-1:0]      res_d;
    logic [SLICES-1:0] cout_d;
    logic [SLICES-1:0] carry_d;
    logic [SLICES-1:0] zero_d;
    logic [SLICES-1:0] neg_d;
    logic [1:0]        mode_q;

    simd_rotl #(.W(W)) u_rot (
        .din  (opb),
        .amt  (rot_amt),
        .dout (b_rot)
    );

    simd_slice_alu #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_alu (
        .mode (mode),
        .op   (op),
        .a    (opa),
        .b    (b_rot),
        .res  (res_d),
        .cout (cout_d)
    );

    simd_flag_gen #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_flags (
        .mode  (mode),
        .op    (op),
        .res   (res_d),
        .cout  (cout_d),
        .carry (carry_d),
        .zero  (zero_d),
        .neg   (neg_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result      <= '0;
            carry_flags <= '0;
            zero_flags  <= '0;
            neg_flags   <= '0;
            mode_q      <= '0;
        end else begin
            result      <= res_d;
            carry_flags <= carry_d;
            zero_flags  <= zero_d;
            neg_flags   <= neg_d;
            mode_q      <= mode;
        end
    end

    simd_mask_expand #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_mask (
        .mode  (mode_q),
        .sel   (mask_sel),
        .carry (carry_flags),
        .zero  (zero_flags),
        .neg   (neg_flags),
        .mask  (lane_mask)
    );
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
    parameter int SLICE_W = 8,
    parameter int SLICES  = 4,
    localparam int W      = SLICE_W * SLICES,
    localparam int RW     = $clog2(W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [2:0]        op,
    input logic [W-1:0]      opa,
    input logic [W-1:0]      opb,
    input logic [RW-1:0]     rot_amt,
    input logic [1:0]        mask_sel,
    input logic [W-1:0]      result,
    input logic [SLICES-1:0] carry_flags,
    input logic [SLICES-1:0] zero_flags,
    input logic [SLICES-1:0] neg_flags,
    input logic [W-1:0]      lane_mask
);
    always_comb begin
        if (!rst_n) begin
            a_reset_clear_r1: assert (result == '0 && carry_flags == '0 && zero_flags == '0
                                      && neg_flags == '0 && lane_mask == '0);
        end
    end

    p_and_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2 && rot_amt == '0) |=> result == $past(opa & opb));

    p_pass_unrotated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5 && rot_amt == '0) |=> result == $past(opb));

    p_byte_isolation_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && op == 3'd0 && rot_amt == '0) |=>
        result[2*SLICE_W-1:SLICE_W] == ($past(opa[2*SLICE_W-1:SLICE_W]) + $past(opb[2*SLICE_W-1:SLICE_W])));

    p_logic_carry_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op >= 3'd2) |=> carry_flags == '0);

    p_zero_lane0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |=> zero_flags[0] == (result[SLICE_W-1:0] == '0));

    p_unused_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (carry_flags[SLICES-1:1] == '0 && zero_flags[SLICES-1:1] == '0
                            && neg_flags[SLICES-1:1] == '0));

    p_mask_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_sel == 2'd3) |-> lane_mask == '0);
endmodule

bind simd_alu simd_alu_chk #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .op          (op),
    .opa         (opa),
    .opb         (opb),
    .rot_amt     (rot_amt),
    .mask_sel    (mask_sel),
    .result      (result),
    .carry_flags (carry_flags),
    .zero_flags  (zero_flags),
    .neg_flags   (neg_flags),
    .lane_mask   (lane_mask)
);

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
module sim_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = '0;
    logic [2:0]  op = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  rot_amt = '0;
    logic [1:0]  mask_sel = '0;
    logic [31:0] result;
    logic [3:0]  carry_flags;
    logic [3:0]  zero_flags;
    logic [3:0]  neg_flags;
    logic [31:0] lane_mask;

    int checks = 0;
    int errors = 0;
    logic [31:0] prev_res = '0;
    bit done = 0;

    always #4 clk = ~clk;

    simd_alu u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .op(op), .opa(opa), .opb(opb),
        .rot_amt(rot_amt), .mask_sel(mask_sel), .result(result),
        .carry_flags(carry_flags), .zero_flags(zero_flags),
        .neg_flags(neg_flags), .lane_mask(lane_mask)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected outputs, built from the requirement text lane by lane.
    task automatic model(input logic [1:0] m, input logic [2:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] r, input logic [1:0] ms,
                         output logic [31:0] er, output logic [3:0] ec,
                         output logic [3:0] ez, output logic [3:0] en, output logic [31:0] em);
        logic [31:0] br;
        logic [63:0] lm, al, bl, rl, s;
        logic [3:0]  pick;
        int nl, lw;
        br = '0;
        for (int i = 0; i < 32; i++) br[(i + r) % 32] = b[i];
        nl = (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
        lw = 32 / nl;
        er = '0; ec = '0; ez = '0; en = '0; em = '0;
        lm = (64'd1 << lw) - 64'd1;
        for (int l = 0; l < nl; l++) begin
            al = ({32'd0, a} >> (l * lw)) & lm;
            bl = ({32'd0, br} >> (l * lw)) & lm;
            case (o)
                3'd0: begin s = al + bl; rl = s & lm; ec[l] = s[lw]; end
                3'd1: begin rl = (al - bl) & lm; ec[l] = (al >= bl); end
                3'd2: rl = al & bl;
                3'd3: rl = al | bl;
                3'd4: rl = al ^ bl;
                default: rl = bl;
            endcase
            er = er | 32'(rl << (l * lw));
            ez[l] = (rl == 64'd0);
            en[l] = rl[lw-1];
        end
        pick = (ms == 2'd0) ? ec : (ms == 2'd1) ? ez : (ms == 2'd2) ? en : 4'd0;
        for (int l = 0; l < nl; l++) begin
            if (pick[l]) em = em | 32'(lm << (l * lw));
        end
    endtask

    task automatic run(input logic [1:0] m, input logic [2:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] r, input logic [1:0] ms,
                       input string tag);
        logic [31:0] er, em;
        logic [3:0]  ec, ez, en;
        model(m, o, a, b, r, ms, er, ec, ez, en, em);
        @(negedge clk);
        mode = m; op = o; opa = a; opb = b; rot_amt = r; mask_sel = ms;
        #1;
        chk("R2", "result before edge", result, prev_res);
        @(posedge clk);
        #2;
        chk(tag, "result", result, er);
        chk(tag, "carry", {28'd0, carry_flags}, {28'd0, ec});
        chk(tag, "zero", {28'd0, zero_flags}, {28'd0, ez});
        chk(tag, "neg", {28'd0, neg_flags}, {28'd0, en});
        chk(tag, "mask", lane_mask, em);
        prev_res = er;
    endtask

    function automatic logic [31:0] biased();
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            case ($urandom % 3)
                0: v[k*8 +: 8] = 8'h00;
                1: v[k*8 +: 8] = 8'hFF;
                default: v[k*8 +: 8] = 8'($urandom);
            endcase
        end
        return v;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state, all mask selections
        repeat (2) @(posedge clk);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            mask_sel = 2'(s);
            #1;
            chk("R1", "reset result", result, 32'd0);
            chk("R1", "reset flags", {20'd0, carry_flags, zero_flags, neg_flags}, 32'd0);
            chk("R1", "reset mask", lane_mask, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        prev_res = result;

        // R5: carries stop at lane edges
        run(2'd2, 3'd0, 32'h00FF00FF, 32'h00010001, 5'd0, 2'd0, "R5");
        run(2'd1, 3'd0, 32'h0000FFFF, 32'h00000001, 5'd0, 2'd0, "R5");
        run(2'd0, 3'd0, 32'hFFFFFFFF, 32'h00000001, 5'd0, 2'd0, "R6");
        run(2'd3, 3'd0, 32'hFFFFFFFF, 32'h01010101, 5'd0, 2'd1, "R5");
        // R6: subtract carry means no borrow
        run(2'd2, 3'd1, 32'h10203040, 32'h10213F40, 5'd0, 2'd0, "R6");
        run(2'd1, 3'd1, 32'h00000000, 32'h00010001, 5'd0, 2'd2, "R6");
        // R7: equal operands give zero lanes
        run(2'd1, 3'd1, 32'h8000ABCD, 32'h7FFFABCD, 5'd0, 2'd1, "R7");
        // R4: rotations
        run(2'd0, 3'd5, 32'h0, 32'h80000001, 5'd31, 2'd2, "R4");
        run(2'd0, 3'd5, 32'h0, 32'h12345678, 5'd0, 2'd2, "R4");
        run(2'd2, 3'd4, 32'hFFFFFFFF, 32'h000000F0, 5'd4, 2'd2, "R4");
        // R3: logic ops and codes 6/7
        run(2'd0, 3'd2, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0, 2'd0, "R3");
        run(2'd0, 3'd3, 32'hF0F0F0F0, 32'h0F00FF00, 5'd0, 2'd1, "R3");
        run(2'd2, 3'd6, 32'h11111111, 32'h8000FF00, 5'd0, 2'd2, "R3");
        run(2'd1, 3'd7, 32'h11111111, 32'h00800080, 5'd8, 2'd2, "R3");
        // R8: unused lanes cleared even when the result is zero everywhere
        run(2'd0, 3'd1, 32'h0, 32'h0, 5'd0, 2'd1, "R8");
        run(2'd1, 3'd0, 32'h0, 32'h0, 5'd0, 2'd1, "R8");
        // R9: each mask selection on one stored result
        run(2'd2, 3'd0, 32'h80FF0080, 32'h00010080, 5'd0, 2'd0, "R9");
        run(2'd2, 3'd0, 32'h80FF0080, 32'h00010080, 5'd0, 2'd1, "R9");
        run(2'd2, 3'd0, 32'h80FF0080, 32'h00010080, 5'd0, 2'd2, "R9");
        run(2'd2, 3'd0, 32'h80FF0080, 32'h00010080, 5'd0, 2'd3, "R9");

        // Random mix, operands biased toward lane-edge carries (R3 R6 R7 R9)
        for (int i = 0; i < 600; i++) begin
            run(2'($urandom), 3'($urandom % 8),
                (i % 2 == 0) ? biased() : $urandom,
                (i % 3 == 0) ? biased() : $urandom,
                (i % 4 == 0) ? 5'd0 : 5'($urandom), 2'($urandom), "R3");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule